// File: doc/BRIEF.md
# Pipelined Small Instruction Memory

This block is a read-only store of 256 bytes that returns one 32-bit word for each byte address it is given. The bytes are arranged as eight rows of 256 bits. Each read goes through two register stages. The first stage picks the row named by the top address bits and registers it. The second stage picks one word out of that row and registers it. A request is accepted on every clock, and its answer appears a fixed two cycles later. The path never stalls.

The contents are computed when the design is elaborated, from a seed parameter, so no file is needed. A fetch unit drives an address together with a valid flag. It gets back a data word together with a valid flag, in the same order as the requests. Reads are word-aligned: the two lowest address bits are dropped.

Top module: `imem_pipe_rom`

## Requirements
- R1: The byte at address a holds (7*a + INIT_SEED) mod 256, where INIT_SEED is an 8-bit parameter with default 8'h3C.
- R2: A valid response carries the four bytes at word address req_addr[7:2], little-endian: rsp_data[8k+7:8k] is the byte at address {req_addr[7:2], k} for k = 0..3. Row req_addr[7:5] is picked in the first stage and word req_addr[4:2] within that row in the second.
- R3: req_addr[1:0] has no effect: addresses that differ only in those bits return the same word.
- R4: A request sampled with req_valid high at clock edge N shows rsp_valid high, with its data, just after edge N+1 and for the whole cycle up to edge N+2 (two-cycle latency).
- R5: Requests on consecutive cycles are all served, one response per cycle, in request order, without stalls.
- R6: A cycle with req_valid low yields a cycle with rsp_valid low, two cycles later.
- R7: While no valid response is presented, rsp_data holds the data of the most recent valid response (zero if there has been none since reset).
- R8: A synchronous active-low reset clears rsp_valid and rsp_data to zero at the next clock edge.
- R9: Requests in flight when reset is applied are dropped: rsp_valid stays low after reset until a new request has been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present this cycle |
| req_addr | input | 8 | Byte address of the read |
| rsp_valid | output | 1 | Response word present this cycle |
| rsp_data | output | 32 | Word read, little-endian byte order |

## Verification
The bench looks for a word that is one position off inside a row, for example from a swapped or shifted word-index slice, by sweeping every word address and comparing it against the content formula. It also looks for a wrong row, which would show up as a correct low byte pattern but an offset of 32 bytes. A short or long pipeline would show the valid flag one cycle early or late, so back-to-back streams with gaps in them are checked cycle by cycle. Offset bits that leak into the word select would return a neighbouring word. Data registers that load on empty cycles would change rsp_data during gaps. A reset that clears only one stage would let a stale response come out after reset is released.

// File: rtl/imem_pkg.sv
// Package: shared content function for the pipelined instruction store.
// Assumes byte addresses fit in 32 bits; the content rule is fixed here so
// every stage and every checker computes the same byte value.
package imem_pkg;

    // Content of one byte: an odd multiplier keeps every value distinct over 256 bytes.
    function automatic logic [7:0] rom_byte(input logic [31:0] byte_addr,
                                            input logic [7:0]  seed);
        logic [31:0] t;
        t = (byte_addr * 32'd7) + {24'd0, seed};
        return t[7:0];
    endfunction

endpackage

// File: rtl/imem_row_bank.sv
// Module: imem_row_bank
// Holds every row as a constant vector computed at elaboration and drives
// the row named by row_idx through a one-hot AND-OR selector.
// Assumes ROWS is a power of two and ROW_IDX_W = log2(ROWS).
module imem_row_bank
    import imem_pkg::*;
#(
    parameter int          ROWS      = 8,
    parameter int          ROW_BYTES = 32,
    parameter logic [7:0]  SEED      = 8'h3C,
    localparam int         ROW_BITS  = ROW_BYTES * 8,
    localparam int         ROW_IDX_W = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROW_IDX_W-1:0] row_idx,
    output logic [ROW_BITS-1:0]  row_data
);

    logic [ROW_BITS-1:0] rows_q [ROWS];
    logic [ROWS-1:0]     row_hit;

    // Fill each row byte from the package content rule.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
            assign rows_q[r][8*b +: 8] = rom_byte(32'(r * ROW_BYTES + b), SEED);
        end
        // One decode line per row.
        assign row_hit[r] = (row_idx == ROW_IDX_W'(r));
    end

    // Combine the rows under their decode lines.
    always_comb begin
        row_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_data = row_data | (rows_q[r] & {ROW_BITS{row_hit[r]}});
        end
    end

    // R2
    row_decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(row_hit));

endmodule

// File: rtl/imem_row_stage.sv
// Module: imem_row_stage
// First pipeline stage: registers the selected row and carries the word
// index and valid flag forward. Row and index load only with a valid request.
// Assumes a synchronous active-low reset.
module imem_row_stage #(
    parameter int ROW_BITS   = 256,
    parameter int WORD_IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [ROW_BITS-1:0]   in_row,
    input  logic [WORD_IDX_W-1:0] in_word_idx,
    output logic                  out_valid,
    output logic [ROW_BITS-1:0]   out_row,
    output logic [WORD_IDX_W-1:0] out_word_idx
);

    // Valid flag follows the request every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Payload captured only for real requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_row      <= '0;
            out_word_idx <= '0;
        end else if (in_valid) begin
            out_row      <= in_row;
            out_word_idx <= in_word_idx;
        end
    end

    // R4
    row_valid_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    row_bubble_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    row_reset_flush_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: rtl/imem_word_mux.sv
// Module: imem_word_mux
// Second pipeline stage: slices the registered row into words, picks one by
// index and registers it with its valid flag. Data loads only on valid.
// Assumes word 0 sits in the least significant bits of the row.
module imem_word_mux #(
    parameter int ROW_BITS      = 256,
    parameter int WORD_W        = 32,
    localparam int WORDS_PER_ROW = ROW_BITS / WORD_W,
    localparam int WORD_IDX_W    = $clog2(WORDS_PER_ROW)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [ROW_BITS-1:0]   in_row,
    input  logic [WORD_IDX_W-1:0] in_word_idx,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_data
);

    logic [WORD_W-1:0] words [WORDS_PER_ROW];
    logic [WORD_W-1:0] picked;

    // Cut the row into word lanes.
    for (genvar w = 0; w < WORDS_PER_ROW; w++) begin : g_lane
        assign words[w] = in_row[w*WORD_W +: WORD_W];
    end

    // Pick the lane named by the carried index.
    always_comb picked = words[in_word_idx];

    // Valid flag follows stage one.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Data captured only for real requests; held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= picked;
    end

    // R4
    word_valid_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    word_bubble_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R8
    word_reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

endmodule

// File: rtl/imem_pipe_rom.sv
// Module: imem_pipe_rom (top)
// Two-stage read-only instruction store: the row is picked from the top
// address bits in stage one, the word from the middle bits in stage two.
// Assumes word-aligned use; the byte-offset bits are dropped.
module imem_pipe_rom #(
    parameter int         ADDR_W    = 8,
    parameter int         WORD_W    = 32,
    parameter int         ROW_BYTES = 32,
    parameter logic [7:0] INIT_SEED = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data
);

    localparam int DEPTH_BYTES   = 2 ** ADDR_W;
    localparam int ROW_BITS      = ROW_BYTES * 8;
    localparam int ROWS          = DEPTH_BYTES / ROW_BYTES;
    localparam int WORD_BYTES    = WORD_W / 8;
    localparam int WORDS_PER_ROW = ROW_BYTES / WORD_BYTES;
    localparam int BYTE_OFF_W    = $clog2(WORD_BYTES);
    localparam int WORD_IDX_W    = $clog2(WORDS_PER_ROW);
    localparam int ROW_IDX_W     = $clog2(ROWS);

    logic [ROW_IDX_W-1:0]  row_idx;
    logic [WORD_IDX_W-1:0] word_idx;
    logic                  unused_offset;
    logic [ROW_BITS-1:0]   row_sel;
    logic                  s1_valid;
    logic [ROW_BITS-1:0]   s1_row;
    logic [WORD_IDX_W-1:0] s1_word_idx;

    // Split the byte address into row, word and dropped offset fields.
    assign row_idx       = req_addr[ADDR_W-1 -: ROW_IDX_W];
    assign word_idx      = req_addr[BYTE_OFF_W +: WORD_IDX_W];
    assign unused_offset = ^req_addr[BYTE_OFF_W-1:0];

    imem_row_bank #(
        .ROWS      (ROWS),
        .ROW_BYTES (ROW_BYTES),
        .SEED      (INIT_SEED)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_idx  (row_idx),
        .row_data (row_sel)
    );

    imem_row_stage #(
        .ROW_BITS   (ROW_BITS),
        .WORD_IDX_W (WORD_IDX_W)
    ) u_stage1 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (req_valid),
        .in_row       (row_sel),
        .in_word_idx  (word_idx),
        .out_valid    (s1_valid),
        .out_row      (s1_row),
        .out_word_idx (s1_word_idx)
    );

    imem_word_mux #(
        .ROW_BITS (ROW_BITS),
        .WORD_W   (WORD_W)
    ) u_stage2 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (s1_valid),
        .in_row      (s1_row),
        .in_word_idx (s1_word_idx),
        .out_valid   (rsp_valid),
        .out_data    (rsp_data)
    );

    // R5
    pipe_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> rsp_valid);

endmodule

// File: tb/imem_pipe_rom_test.sv
module imem_pipe_rom_test;

    localparam logic [7:0] SEED = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    imem_pipe_rom #(.INIT_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Table entries: {valid, address}
    localparam logic [8:0] VEC [0:15] = '{
        9'h100, 9'h104, 9'h11F, 9'h120, 9'h0AA, 9'h1FF, 9'h1FC, 9'h000,
        9'h000, 9'h183, 9'h160, 9'h0FC, 9'h1E9, 9'h13B, 9'h1C4, 9'h000
    };

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ba;
            ba = {a[7:2], 2'(k)};
            w[8*k +: 8] = 8'((32'(ba) * 7 + 32'(SEED)) & 32'hFF);
        end
        return w;
    endfunction

    logic        pv [0:1];
    logic [31:0] pd [0:1];
    string       pt [0:1];
    int          fill = 0;
    logic [31:0] model_d = '0;

    task automatic check(input string tag, input logic v_exp, input logic [31:0] d_exp);
        checks++;
        if (rsp_valid !== v_exp || rsp_data !== d_exp) begin
            fails++;
            $display("FAIL %s: rsp_valid=%b rsp_data=%h expected valid=%b data=%h",
                     tag, rsp_valid, rsp_data, v_exp, d_exp);
        end
    endtask

    // Drive one request at a falling edge; check the one issued two cycles earlier.
    task automatic issue(input logic v, input logic [7:0] a, input string tag);
        @(negedge clk);
        if (fill >= 2) check(pt[0], pv[0], pd[0]);
        pv[0] = pv[1]; pd[0] = pd[1]; pt[0] = pt[1];
        if (v) model_d = exp_word(a);
        pv[1] = v; pd[1] = model_d; pt[1] = tag;
        fill++;
        req_valid = v;
        req_addr  = a;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: state held in reset from time zero
        repeat (2) @(negedge clk);
        check("R8 initial reset", 1'b0, 32'h0);
        rst_n = 1'b1;

        // Table walk: R2/R4 on valid entries, R6/R7 on gaps
        for (int i = 0; i < 16; i++) begin
            issue(VEC[i][8], VEC[i][7:0], VEC[i][8] ? "R2 R4 table read" : "R6 R7 table gap");
        end

        // R1 R5: every word, back to back, with rotating offset bits
        for (int w = 0; w < 64; w++) begin
            issue(1'b1, {6'(w), 2'(w % 4)}, "R1 R5 sweep");
        end
        issue(1'b0, 8'h00, "R6 R7 after sweep");
        issue(1'b0, 8'h00, "R6 R7 after sweep");

        // R3: offset bits ignored
        issue(1'b1, 8'hA1, "R3 offset 1");
        issue(1'b1, 8'hA2, "R3 offset 2");
        issue(1'b1, 8'hA3, "R3 offset 3");
        issue(1'b1, 8'hA0, "R3 offset 0");
        issue(1'b0, 8'hA3, "R7 invalid with address");
        issue(1'b0, 8'h00, "R7 hold");
        issue(1'b0, 8'h00, "R7 hold");

        // R8 R9: reset with requests in flight
        issue(1'b1, 8'h10, "R2 pre-reset");
        issue(1'b1, 8'h14, "R2 pre-reset");
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b1; req_addr = 8'h18;
        @(negedge clk);
        check("R8 reset mid-stream", 1'b0, 32'h0);
        rst_n = 1'b1; req_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R9 flushed after reset", 1'b0, 32'h0);
        end
        fill = 0; model_d = '0;
        issue(1'b1, 8'hFC, "R4 after reset");
        issue(1'b0, 8'h00, "R6 after reset");
        issue(1'b0, 8'h00, "R7 after reset");
        issue(1'b0, 8'h00, "R7 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule